// File: doc/BRIEF.md
# Fractional Baud Prescaler with Clock Insertion

This block sits between a serial clock source and the baud-rate divider chain of a serial transmitter and receiver. It turns the input clock into a stream of enable pulses, each one input clock wide. Each pulse closes one output period. An 8-bit control word chooses an integer divisor from 2 to 8, or a bypass in which every input clock produces a pulse. The same word also holds an insertion count N. In each frame of 32 output periods, N periods are lengthened by one extra input clock, so the average divisor is PD + N/32. The lengthened periods are spread evenly across the frame by an accumulator rather than grouped together.

Software writes the control word through a single write strobe. The value is staged in a pending register and only takes effect when the current output period ends, so a period in progress always runs to its full length. The later divider stages turn the pulse rate into a baud rate of f / (64 × BPD × BD × (PD + N/32)).

Internally, a state machine has three states. ST_BYPASS emits a pulse on every clock. ST_COUNT counts down the integer part of the period. ST_EXTRA is the single inserted clock of a lengthened period.

Every pulse is a boundary. At a boundary the machine takes one of three transitions, chosen from the pending word:
- load-bypass goes to ST_BYPASS when the select is zero.
- load-count goes to ST_COUNT with the count preset.
- count-down stays in ST_COUNT while the count is nonzero.

When the count reaches zero, one of two things happens:
- insert goes to ST_EXTRA if the period was marked as stretched.
- Otherwise the machine pulses and takes a load transition at once.

ST_EXTRA always pulses and then takes a load transition.

Top module: `frac_baud_prescaler`

## Requirements
- R1: The control word is 8 bits. Bits 7:5 are the divisor select S and bits 4:0 are the insertion count N.
- R2: With S = 0 the output enable is high on every input clock, whatever the value of N. The fine adjustment has no effect.
- R3: With S = 1..7 and N = 0, every output period lasts exactly S+1 input clocks (divisors 2 to 8).
- R4: With S nonzero and N constant, any 32 consecutive output periods span exactly 32×(S+1)+N input clocks.
- R5: When a divided mode is entered from bypass, period k of a frame (k = 0..31) lasts S+1 clocks, plus one extra clock when floor((k+1)N/32) > floor(kN/32).
- R6: In a divided mode the enable pulse is one input clock wide and is followed by at least one clock with the enable low.
- R7: Reset clears the control word to zero, so the block comes out of reset in bypass with the enable high on every clock.
- R8: A write takes effect at the next period boundary. The period in progress keeps the length set by the word in force when it began, including a change into bypass.
- R9: The frame of 32 periods repeats: the stretch pattern of periods 32..63 equals that of periods 0..31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock source; every edge is one input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word: select in 7:5, insertion count in 4:0 |
| baud_en | output | 1 | One-clock enable pulse marking the end of each output period |

## Verification
The divider is exercised three ways:
- Each integer select with N = 0 shows that the count preset maps the code to the right divisor.
- N = 1, 7, 16 and 31 at several divisors test the accumulator's carry pattern. A sparse N shows even spreading, a half frame shows alternation, and a nearly full frame shows stretching on all but one period. Each pattern is checked period by period and as a frame total.
- Bypass with a nonzero N shows that the fine adjustment is disabled.

Writes made in the middle of a period, one to a smaller divisor and one into bypass, separate boundary-aligned loading from an immediate reload that would cut a period short.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXTRA  = 2'd2
    } fbp_state_e;

endpackage

// File: rtl/fbp_cfg_reg.sv
module fbp_cfg_reg #(
    parameter int SEL_W = 3,
    parameter int INS_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SEL_W+INS_W-1:0] wdata,
    output logic [SEL_W+INS_W-1:0] pend_cfg,
    output logic [SEL_W-1:0]       pend_sel,
    output logic [INS_W-1:0]       pend_ins
);
    localparam int CFG_W = SEL_W + INS_W;

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    assign pend_cfg = cfg_q;
    assign pend_sel = cfg_q[CFG_W-1:INS_W];
    assign pend_ins = cfg_q[INS_W-1:0];

endmodule

// File: rtl/fbp_accum.sv
module fbp_accum #(
    parameter int INS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             cur_bypass,
    input  logic             divide_next,
    input  logic [INS_W-1:0] ins,
    output logic             stretch_next
);
    localparam logic [INS_W-1:0] LAST_IDX = '1;

    logic [INS_W-1:0] acc_q;
    logic [INS_W-1:0] frame_q;
    logic [INS_W-1:0] base;
    logic [INS_W:0]   sum;

    // a new frame (or a start from bypass) begins from an empty accumulator
    always_comb begin
        base = (cur_bypass || frame_q == LAST_IDX) ? '0 : acc_q;
        sum  = {1'b0, base} + {1'b0, ins};
        stretch_next = divide_next && sum[INS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            frame_q <= '0;
        end else if (boundary) begin
            if (!divide_next) begin
                acc_q   <= '0;
                frame_q <= '0;
            end else begin
                acc_q   <= sum[INS_W-1:0];
                frame_q <= cur_bypass ? '0 : frame_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fbp_period_fsm.sv
module fbp_period_fsm
    import fbp_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] pend_sel,
    input  logic             stretch_next,
    output fbp_state_e       state,
    output logic             tick
);
    fbp_state_e       state_q, state_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;
    logic             str_q, str_d;
    logic             load;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        str_d   = str_q;
        load    = 1'b0;
        unique case (state_q)
            ST_BYPASS: load = 1'b1;
            ST_COUNT: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (str_q) begin
                    state_d = ST_EXTRA;
                end else begin
                    load = 1'b1;
                end
            end
            ST_EXTRA: load = 1'b1;
            default:  load = 1'b1;
        endcase
        if (load) begin
            if (pend_sel == '0) begin
                state_d = ST_BYPASS;
                cnt_d   = '0;
                str_d   = 1'b0;
            end else begin
                state_d = ST_COUNT;
                cnt_d   = pend_sel;
                str_d   = stretch_next;
            end
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            cnt_q   <= '0;
            str_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            str_q   <= str_d;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_BYPASS: tick = 1'b1;
            ST_COUNT:  tick = (cnt_q == '0) && !str_q;
            ST_EXTRA:  tick = 1'b1;
            default:   tick = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/frac_baud_prescaler.sv
module frac_baud_prescaler
    import fbp_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int INS_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SEL_W+INS_W-1:0] cfg_wdata,
    output logic                   baud_en
);
    localparam int CFG_W = SEL_W + INS_W;

    logic [CFG_W-1:0] pend_cfg;
    logic [SEL_W-1:0] pend_sel;
    logic [INS_W-1:0] pend_ins;
    logic             stretch_next;
    logic             tick;
    fbp_state_e       fsm_state;

    fbp_cfg_reg #(.SEL_W(SEL_W), .INS_W(INS_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .pend_cfg (pend_cfg),
        .pend_sel (pend_sel),
        .pend_ins (pend_ins)
    );

    fbp_accum #(.INS_W(INS_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary     (tick),
        .cur_bypass   (fsm_state == ST_BYPASS),
        .divide_next  (pend_sel != '0),
        .ins          (pend_ins),
        .stretch_next (stretch_next)
    );

    fbp_period_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_sel     (pend_sel),
        .stretch_next (stretch_next),
        .state        (fsm_state),
        .tick         (tick)
    );

    assign baud_en = tick;

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker
    import fbp_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int INS_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input fbp_state_e             state,
    input logic [SEL_W+INS_W-1:0] pend_cfg,
    input logic [INS_W-1:0]       frame_idx
);
    localparam int CFG_W = SEL_W + INS_W;
    localparam int GW    = SEL_W + 2;

    logic [GW-1:0]    gap_q;
    logic [CFG_W-1:0] used_q;

    // cycles since the last pulse, and the word captured at the last boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            used_q <= '0;
        end else if (tick) begin
            gap_q  <= '0;
            used_q <= pend_cfg;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_bypass_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> tick);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_cfg[CFG_W-1:INS_W] != '0) |=> !tick);

    assert_period_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state != ST_BYPASS) |->
        (({2'b00, used_q[CFG_W-1:INS_W]} == gap_q) ||
         ({2'b00, used_q[CFG_W-1:INS_W]} + 1'b1 == gap_q)));

    assert_extra_needs_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTRA) |-> (used_q[INS_W-1:0] != '0));

    assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state != ST_BYPASS && frame_idx == '1 && pend_cfg[CFG_W-1:INS_W] != '0)
        |=> (frame_idx == '0));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (pend_cfg == '0 && state == ST_BYPASS));

endmodule

bind frac_baud_prescaler fbp_checker #(.SEL_W(SEL_W), .INS_W(INS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_en),
    .state     (fsm_state),
    .pend_cfg  (pend_cfg),
    .frame_idx (u_acc.frame_q)
);

// File: tb/frac_baud_prescaler_test.sv
`timescale 1ns/1ps
module frac_baud_prescaler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       baud_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    frac_baud_prescaler uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .baud_en   (baud_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!baud_en);
    endtask

    task automatic go_bypass();
        write_cfg(8'h00);
        repeat (12) @(negedge clk);
    endtask

    function automatic int extra_at(input int k, input int n);
        return (((k + 1) * n) / 32) - ((k * n) / 32);
    endfunction

    task automatic t_reset();
        int highs = 0;
        repeat (3) @(negedge clk);
        check(baud_en == 1'b1, "R7 enable during reset", baud_en, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (baud_en) highs++;
        end
        check(highs == 20, "R7 bypass after reset", highs, 20);
    endtask

    task automatic t_integer(input int sel);
        int len;
        int bad = 0;
        go_bypass();
        write_cfg({sel[2:0], 5'd0});
        for (int i = 0; i < 32; i++) begin
            measure(len);
            if (len != sel + 1) bad++;
        end
        check(bad == 0, "R3/R6 integer periods", bad, 0);
        measure(len);
        check(len == sel + 1, "R3 period length", len, sel + 1);
    endtask

    task automatic t_frac(input int sel, input int n);
        int len;
        int total = 0;
        int bad = 0;
        int again = 0;
        int first [32];
        go_bypass();
        write_cfg({sel[2:0], n[4:0]});
        for (int k = 0; k < 64; k++) begin
            measure(len);
            if (k < 32) begin
                first[k] = len;
                total += len;
                if (len != sel + 1 + extra_at(k, n)) begin
                    bad++;
                    $display("FAIL R5: period %0d actual=%0d expected=%0d", k, len, sel + 1 + extra_at(k, n));
                end
            end else if (len != first[k-32]) begin
                again++;
            end
        end
        checks++;
        check(total == 32 * (sel + 1) + n, "R1/R4 frame total", total, 32 * (sel + 1) + n);
        if (bad != 0) fails++;
        check(again == 0, "R9 second frame repeats", again, 0);
    endtask

    task automatic t_bypass_ins();
        int highs = 0;
        go_bypass();
        write_cfg(8'b000_10101);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_en) highs++;
        end
        check(highs == 40, "R2 bypass ignores count", highs, 40);
    endtask

    task automatic t_midchange();
        int len;
        go_bypass();
        write_cfg({3'd7, 5'd0});
        measure(len);
        check(len == 8, "R3 sync period", len, 8);
        len = 0;
        repeat (3) begin
            @(negedge clk);
            len++;
        end
        write_cfg({3'd1, 5'd0});
        len++;
        while (!baud_en) begin
            @(negedge clk);
            len++;
        end
        check(len == 8, "R8 running period kept", len, 8);
        measure(len);
        check(len == 2, "R8 new divisor applied", len, 2);
        @(negedge clk);
        check(baud_en == 1'b0, "R6 low after pulse", baud_en, 0);
        write_cfg(8'h00);
        check(baud_en == 1'b1, "R8 period ends before bypass", baud_en, 1);
        measure(len);
        check(len == 1, "R2 bypass after boundary", len, 1);
    endtask

    task automatic t_reset_mid();
        int highs = 0;
        go_bypass();
        write_cfg({3'd7, 5'd9});
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(baud_en == 1'b1, "R7 reset forces bypass", baud_en, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (baud_en) highs++;
        end
        check(highs == 20, "R7 word cleared", highs, 20);
    endtask

    initial begin
        t_reset();
        for (int s = 1; s < 8; s++) t_integer(s);
        t_frac(3, 1);
        t_frac(1, 31);
        t_frac(7, 16);
        t_frac(4, 7);
        t_bypass_ins();
        t_midchange();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule